// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Flag Strobes

This combinational unit moves the bits of an 8-, 16- or 32-bit operand. It covers logical shifts in both directions, the sign-preserving right shift, plain rotates, and rotates that pass through the carry. Alongside the result it produces candidate values for the carry, overflow, sign, zero and parity flags. Each flag has its own write strobe. A flag register outside the block keeps its old value whenever the strobe for that flag is low.

The operand size comes from a size code. Only the low byte, the low half or the whole operand takes part in the operation. Operand bits above the selected size reach the result unchanged, so the result can be written straight back into a wider register. The count is first reduced as a function of the operation and the size. When the reduced count is zero, the unit acts as a pure pass-through: the result equals the operand and every strobe is low.

Top module: `shrot_unit`

## Requirements
- R1: Only the low 5 bits of the count input are used. A count of 33 acts as 1, and a count of 32 acts as 0.
- R2: For rotate-through-carry (op codes 5 and 6), the 5-bit count is further reduced modulo 9 for bytes and modulo 17 for halves. For words it is used as is.
- R3: Rotate-through-carry treats the carry as one extra bit above the operand MSB, forming a ring of N+1 bits. The bit that ends up in that extra position becomes the new CF.
- R4: When the effective count is zero, or the op code is 7 (no-op), the following hold: res_o equals opnd_i, all five strobes are low, cf_o equals cf_i, and of_o equals of_i.
- R5: For a left shift (op 0), CF is the last bit shifted out of the MSB end. It is 0 when the count is larger than N.
- R6: For a logical right shift (op 1) and an arithmetic right shift (op 2), CF is bit count-1 of the original sized operand. For the arithmetic shift, bits at or beyond the MSB read as the sign.
- R7: The arithmetic right shift fills the vacated upper bits with the original sign bit. A count of N or more gives all ones or all zeros.
- R8: For the three shifts (ops 0 to 2), the sf, zf and pf strobes are high. SF is the sized result MSB, ZF is set when the sized result is zero, and PF is set when the low result byte has an even number of ones.
- R9: The OF strobe is high only when the effective count is 1. In that case OF is as follows: ops 0, 3 and 5 give result MSB XOR new CF; op 1 gives the original MSB; op 2 gives 0; ops 4 and 6 give result MSB XOR the bit below it.
- R10: A plain rotate left (op 3) or right (op 4) rotates by the count modulo N. New CF is the result LSB for left rotates and the result MSB for right rotates. The sf, zf and pf strobes stay low.
- R11: Size codes are 0 for a byte, 1 for a half, and 2 or 3 for a word. Operand bits above the selected size appear unchanged on res_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to shift or rotate |
| cnt_i | input | 8 | Shift or rotate count |
| op_i | input | 3 | Operation code: 0 shl, 1 shr, 2 sar, 3 rol, 4 ror, 5 rcl, 6 rcr, 7 none |
| size_i | input | 2 | Operand size code |
| cf_i | input | 1 | Current carry flag |
| of_i | input | 1 | Current overflow flag |
| res_o | output | 32 | Result |
| cf_o | output | 1 | Carry flag value |
| of_o | output | 1 | Overflow flag value |
| sf_o | output | 1 | Sign flag value |
| zf_o | output | 1 | Zero flag value |
| pf_o | output | 1 | Parity flag value |
| cf_we_o | output | 1 | Carry flag write strobe |
| of_we_o | output | 1 | Overflow flag write strobe |
| sf_we_o | output | 1 | Sign flag write strobe |
| zf_we_o | output | 1 | Zero flag write strobe |
| pf_we_o | output | 1 | Parity flag write strobe |

## Verification
The embedded checks assume the inputs are settled two-state values whenever they are evaluated. Because the unit has no state, each input combination is judged on its own. The bench meets this by changing every input together on the falling clock edge and reading the outputs only once that half cycle is over. It covers every op code, including the reserved one, with each size code, including the alias code 3. It uses counts that land exactly on the masking and modulo boundaries, and it compares each vector with a bit-at-a-time reference model.

// File: rtl/shrot_pkg.sv
// Shared widths, op codes and size codes for the shift/rotate unit.
// Assumes a 32-bit datapath whose counts are masked to five bits.
package shrot_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_IN_W = 8;
    localparam int CNT_W    = 5;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_NOP = 3'd7
    } shrot_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } shrot_size_e;

    // Number of active operand bits for a size code.
    function automatic int sized_bits(shrot_size_e s);
        case (s)
            SZ_BYTE: return 8;
            SZ_HALF: return 16;
            default: return DATA_W;
        endcase
    endfunction
endpackage

// File: rtl/shrot_cnt_prep.sv
// Count preparation: masks the raw count to CNT_W bits and, for rotates
// through carry, reduces it modulo the ring length (9 or 17).
// Assumes CNT_IN_W >= CNT_W and at most three ring wraps in the range.
module shrot_cnt_prep
    import shrot_pkg::*;
#(
    parameter int CIN_W = CNT_IN_W,
    parameter int CW    = CNT_W
) (
    input  logic [CIN_W-1:0] cnt_i,
    input  shrot_op_e        op_i,
    input  shrot_size_e      size_i,
    output logic [CW-1:0]    cnt_eff_o,
    output logic             act_o,
    output logic             single_o
);
    localparam int BYTE_RING = 9;
    localparam int HALF_RING = 17;

    logic [CW-1:0] masked;
    logic          thru_carry;
    logic          unused_hi_bits;

    // Upper count bits play no part in the operation.
    assign unused_hi_bits = ^cnt_i[CIN_W-1:CW];

    // Mask, then reduce for the carry ring by repeated subtraction.
    always_comb begin
        masked     = cnt_i[CW-1:0];
        thru_carry = (op_i == OP_RCL) || (op_i == OP_RCR);
        cnt_eff_o  = masked;
        if (thru_carry) begin
            case (size_i)
                SZ_BYTE: begin
                    if (masked >= CW'(3 * BYTE_RING))      cnt_eff_o = masked - CW'(3 * BYTE_RING);
                    else if (masked >= CW'(2 * BYTE_RING)) cnt_eff_o = masked - CW'(2 * BYTE_RING);
                    else if (masked >= CW'(BYTE_RING))     cnt_eff_o = masked - CW'(BYTE_RING);
                end
                SZ_HALF: begin
                    if (masked >= CW'(HALF_RING))          cnt_eff_o = masked - CW'(HALF_RING);
                end
                default: cnt_eff_o = masked;
            endcase
        end
    end

    // Activity and single-step decode.
    always_comb begin
        act_o    = (op_i != OP_NOP) && (cnt_eff_o != '0);
        single_o = (cnt_eff_o == CW'(1));
    end

    // Range check on the reduced count.
    always_comb begin
        // R2
        if ((op_i == OP_RCL || op_i == OP_RCR) && size_i == SZ_BYTE)
            rc_byte_range_chk: assert (int'(cnt_eff_o) < BYTE_RING)
                else $error("reduced byte ring count out of range");
        // R2
        if ((op_i == OP_RCL || op_i == OP_RCR) && size_i == SZ_HALF)
            rc_half_range_chk: assert (int'(cnt_eff_o) < HALF_RING)
                else $error("reduced half ring count out of range");
    end
endmodule

// File: rtl/shrot_core.sv
// Bit-moving core: produces the sized result (zero above the selected
// size) and the new carry for every op. Assumes cnt_i is already
// masked/reduced; rotates use a doubled ring so any width works.
module shrot_core
    import shrot_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic [DW-1:0] opnd_i,
    input  logic [CW-1:0] cnt_i,
    input  shrot_op_e     op_i,
    input  shrot_size_e   size_i,
    input  logic          cf_i,
    output logic [DW-1:0] res_o,
    output logic          cf_new_o,
    output logic          orig_msb_o,
    output logic          res_msb_o,
    output logic          res_msb2_o
);
    localparam int WIDE = 3 * DW + 4;

    int              nbits;
    int              ring_len;
    logic [WIDE-1:0] mask_w;
    logic [WIDE-1:0] v_w;
    logic [WIDE-1:0] sx_w;
    logic [WIDE-1:0] wide_w;
    logic [WIDE-1:0] ring_w;
    logic [WIDE-1:0] wmask_w;
    logic [WIDE-1:0] dbl_w;
    logic [WIDE-1:0] rot_w;
    logic [WIDE-1:0] res_w;
    logic [CW-1:0]   k;

    // Size decode and the sized, zero-extended operand.
    always_comb begin
        nbits  = sized_bits(size_i);
        mask_w = (WIDE'(1) << nbits) - WIDE'(1);
        v_w    = WIDE'(opnd_i) & mask_w;
        sx_w   = v_w | (v_w[nbits-1] ? ~mask_w : '0);
    end

    // Per-op result and carry.
    always_comb begin
        wide_w   = '0;
        ring_w   = v_w;
        ring_len = nbits;
        k        = cnt_i;
        wmask_w  = '0;
        dbl_w    = '0;
        rot_w    = '0;
        res_w    = v_w;
        cf_new_o = cf_i;
        case (op_i)
            OP_SHL: begin
                wide_w   = v_w << cnt_i;
                res_w    = wide_w & mask_w;
                cf_new_o = wide_w[nbits];
            end
            OP_SHR: begin
                res_w    = v_w >> cnt_i;
                cf_new_o = (cnt_i != '0) ? v_w[cnt_i - CW'(1)] : 1'b0;
            end
            OP_SAR: begin
                res_w    = (sx_w >> cnt_i) & mask_w;
                cf_new_o = (cnt_i != '0) ? sx_w[cnt_i - CW'(1)] : 1'b0;
            end
            OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
                if (op_i == OP_RCL || op_i == OP_RCR) begin
                    ring_w   = v_w | (WIDE'(cf_i) << nbits);
                    ring_len = nbits + 1;
                    k        = cnt_i;
                end else begin
                    ring_w   = v_w;
                    ring_len = nbits;
                    k        = cnt_i & CW'(nbits - 1);
                end
                wmask_w = (WIDE'(1) << ring_len) - WIDE'(1);
                dbl_w   = (ring_w << ring_len) | ring_w;
                if (op_i == OP_ROL || op_i == OP_RCL)
                    rot_w = ((dbl_w << k) >> ring_len) & wmask_w;
                else
                    rot_w = (dbl_w >> k) & wmask_w;
                res_w = rot_w & mask_w;
                case (op_i)
                    OP_ROL:  cf_new_o = rot_w[0];
                    OP_ROR:  cf_new_o = rot_w[nbits-1];
                    default: cf_new_o = rot_w[nbits];
                endcase
            end
            default: begin
                res_w    = v_w;
                cf_new_o = cf_i;
            end
        endcase
    end

    // Outputs for the flag stage.
    always_comb begin
        res_o      = res_w[DW-1:0];
        orig_msb_o = v_w[nbits-1];
        res_msb_o  = res_w[nbits-1];
        res_msb2_o = res_w[nbits-2];
    end

    // Shift corner checks.
    always_comb begin
        // R7
        if (op_i == OP_SAR && int'(cnt_i) >= nbits)
            sar_fill_chk: assert (res_o == (orig_msb_o ? mask_w[DW-1:0] : '0))
                else $error("arithmetic shift fill wrong");
        // R5
        if (op_i == OP_SHL && int'(cnt_i) > nbits)
            shl_drain_chk: assert (!cf_new_o)
                else $error("left shift carry not drained");
    end
endmodule

// File: rtl/shrot_flags.sv
// Flag stage: computes SF/ZF/PF from the sized result, OF per op for a
// single step, and the per-flag write strobes. Assumes res_i is zero
// above the selected size.
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] res_i,
    input  logic          res_msb_i,
    input  logic          res_msb2_i,
    input  logic          orig_msb_i,
    input  logic          cf_new_i,
    input  shrot_op_e     op_i,
    input  logic          act_i,
    input  logic          single_i,
    input  logic          cf_i,
    input  logic          of_i,
    output logic          cf_o,
    output logic          of_o,
    output logic          sf_o,
    output logic          zf_o,
    output logic          pf_o,
    output logic          cf_we_o,
    output logic          of_we_o,
    output logic          sf_we_o,
    output logic          zf_we_o,
    output logic          pf_we_o
);
    logic is_shift;
    logic of_val;

    // Result-derived flags.
    always_comb begin
        sf_o = res_msb_i;
        zf_o = (res_i == '0);
        pf_o = ~^res_i[7:0];
    end

    // Single-step overflow value per op.
    always_comb begin
        case (op_i)
            OP_SHL, OP_ROL, OP_RCL: of_val = res_msb_i ^ cf_new_i;
            OP_SHR:                 of_val = orig_msb_i;
            OP_ROR, OP_RCR:         of_val = res_msb_i ^ res_msb2_i;
            default:                of_val = 1'b0;
        endcase
    end

    // Strobes and held/new CF and OF.
    always_comb begin
        is_shift = (op_i == OP_SHL) || (op_i == OP_SHR) || (op_i == OP_SAR);
        cf_we_o  = act_i;
        of_we_o  = act_i && single_i;
        sf_we_o  = act_i && is_shift;
        zf_we_o  = act_i && is_shift;
        pf_we_o  = act_i && is_shift;
        cf_o     = act_i ? cf_new_i : cf_i;
        of_o     = of_we_o ? of_val : of_i;
    end
endmodule

// File: rtl/shrot_unit.sv
// Top of the shift/rotate unit: count preparation, bit-moving core and
// flag stage, plus the merge that passes operand bits above the
// selected size. Purely combinational; the caller owns the flag register.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int CIN_W = CNT_IN_W,
    parameter int CW    = CNT_W
) (
    input  logic [DW-1:0]    opnd_i,
    input  logic [CIN_W-1:0] cnt_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       size_i,
    input  logic             cf_i,
    input  logic             of_i,
    output logic [DW-1:0]    res_o,
    output logic             cf_o,
    output logic             of_o,
    output logic             sf_o,
    output logic             zf_o,
    output logic             pf_o,
    output logic             cf_we_o,
    output logic             of_we_o,
    output logic             sf_we_o,
    output logic             zf_we_o,
    output logic             pf_we_o
);
    shrot_op_e   op_e;
    shrot_size_e size_e;
    logic [CW-1:0] cnt_eff;
    logic          act;
    logic          single;
    logic [DW-1:0] core_res;
    logic          cf_new;
    logic          orig_msb;
    logic          res_msb;
    logic          res_msb2;
    logic [DW-1:0] sz_mask;

    assign op_e   = shrot_op_e'(op_i);
    assign size_e = shrot_size_e'(size_i);

    shrot_cnt_prep #(.CIN_W(CIN_W), .CW(CW)) cnt_prep_i (
        .cnt_i     (cnt_i),
        .op_i      (op_e),
        .size_i    (size_e),
        .cnt_eff_o (cnt_eff),
        .act_o     (act),
        .single_o  (single)
    );

    shrot_core #(.DW(DW), .CW(CW)) core_i (
        .opnd_i     (opnd_i),
        .cnt_i      (cnt_eff),
        .op_i       (op_e),
        .size_i     (size_e),
        .cf_i       (cf_i),
        .res_o      (core_res),
        .cf_new_o   (cf_new),
        .orig_msb_o (orig_msb),
        .res_msb_o  (res_msb),
        .res_msb2_o (res_msb2)
    );

    shrot_flags #(.DW(DW)) flags_i (
        .res_i      (core_res),
        .res_msb_i  (res_msb),
        .res_msb2_i (res_msb2),
        .orig_msb_i (orig_msb),
        .cf_new_i   (cf_new),
        .op_i       (op_e),
        .act_i      (act),
        .single_i   (single),
        .cf_i       (cf_i),
        .of_i       (of_i),
        .cf_o       (cf_o),
        .of_o       (of_o),
        .sf_o       (sf_o),
        .zf_o       (zf_o),
        .pf_o       (pf_o),
        .cf_we_o    (cf_we_o),
        .of_we_o    (of_we_o),
        .sf_we_o    (sf_we_o),
        .zf_we_o    (zf_we_o),
        .pf_we_o    (pf_we_o)
    );

    // Size mask for the upper-bit merge.
    always_comb begin
        case (size_e)
            SZ_BYTE: sz_mask = DW'(8'hFF);
            SZ_HALF: sz_mask = DW'(16'hFFFF);
            default: sz_mask = '1;
        endcase
    end

    // Merge sized result with untouched upper operand bits.
    always_comb begin
        res_o = act ? ((opnd_i & ~sz_mask) | core_res) : opnd_i;
    end

    // Cross-stage checks on strobes and pass-through.
    always_comb begin
        // R4
        if (!cf_we_o)
            idle_hold_chk: assert (res_o == opnd_i && !of_we_o && !sf_we_o && !zf_we_o && !pf_we_o
                                   && cf_o == cf_i && of_o == of_i)
                else $error("idle op changed state");
        // R10
        if (op_e == OP_ROL || op_e == OP_ROR || op_e == OP_RCL || op_e == OP_RCR)
            rot_quiet_chk: assert (!sf_we_o && !zf_we_o && !pf_we_o)
                else $error("rotate touched result flags");
        // R9
        if (of_we_o)
            of_single_chk: assert (cf_we_o && cnt_eff == CW'(1))
                else $error("overflow strobe without single step");
        // R11
        if (size_e == SZ_BYTE)
            upper_pass_chk: assert (res_o[DW-1:8] == opnd_i[DW-1:8])
                else $error("upper operand bits changed");
    end
endmodule

// File: tb/shrot_unit_tb.sv
// Directed bench for shrot_unit, with a bit-at-a-time reference model.
module shrot_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd;
    logic [7:0]  cnt;
    logic [2:0]  op;
    logic [1:0]  size;
    logic        cf_in, of_in;
    logic [31:0] res;
    logic        cf_o, of_o, sf_o, zf_o, pf_o;
    logic        cf_we, of_we, sf_we, zf_we, pf_we;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    shrot_unit dut_i (
        .opnd_i(opnd), .cnt_i(cnt), .op_i(op), .size_i(size),
        .cf_i(cf_in), .of_i(of_in), .res_o(res),
        .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o),
        .cf_we_o(cf_we), .of_we_o(of_we), .sf_we_o(sf_we), .zf_we_o(zf_we), .pf_we_o(pf_we)
    );

    // Reference: steps one bit at a time, following the requirements.
    task automatic model(input int mop, input int msz, input logic [31:0] x, input int mcnt,
                         input logic ci, input logic oi,
                         output logic [31:0] r, output logic [11:0] fl);
        int nb;
        int k;
        longint unsigned mask, v;
        logic c, t, co, oo, sf, zf, pf, cwe, owe, swe;
        nb = (msz == 0) ? 8 : (msz == 1) ? 16 : 32;
        mask = (64'd1 << nb) - 64'd1;
        v = {32'd0, x} & mask;
        k = mcnt & 31;
        if (mop == 5 || mop == 6) begin
            if (nb == 8) k = k % 9;
            else if (nb == 16) k = k % 17;
        end
        r = x; co = ci; oo = oi; sf = 0; zf = 0; pf = 0; cwe = 0; owe = 0; swe = 0;
        if (mop != 7 && k != 0) begin
            c = ci;
            for (int i = 0; i < k; i++) begin
                case (mop)
                    0: begin c = v[nb-1]; v = (v << 1) & mask; end
                    1: begin c = v[0]; v = v >> 1; end
                    2: begin c = v[0]; v = (v >> 1) | (v & (64'd1 << (nb-1))); end
                    3: begin c = v[nb-1]; v = ((v << 1) | 64'(c)) & mask; end
                    4: begin c = v[0]; v = (v >> 1) | (64'(c) << (nb-1)); end
                    5: begin t = v[nb-1]; v = ((v << 1) | 64'(c)) & mask; c = t; end
                    default: begin t = v[0]; v = (v >> 1) | (64'(c) << (nb-1)); c = t; end
                endcase
            end
            r = (x & ~mask[31:0]) | v[31:0];
            co = c; cwe = 1;
            if (mop <= 2) begin
                swe = 1; sf = v[nb-1]; zf = (v == 0); pf = ~^v[7:0];
            end
            if (k == 1) begin
                owe = 1;
                case (mop)
                    0, 3, 5: oo = v[nb-1] ^ c;
                    1:       oo = x[nb-1];
                    2:       oo = 1'b0;
                    default: oo = v[nb-1] ^ v[nb-2];
                endcase
            end
        end
        fl = {co, oo, cwe, owe, swe, swe, swe, sf & swe, zf & swe, pf & swe, 2'b00};
    endtask

    // Apply one vector, compare all outputs with the model.
    task automatic check_vec(input string tag, input int mop, input int msz, input logic [31:0] x,
                             input int mcnt, input logic ci, input logic oi);
        logic [31:0] er;
        logic [11:0] ef, gf;
        model(mop, msz, x, mcnt, ci, oi, er, ef);
        @(negedge clk);
        op = mop[2:0]; size = msz[1:0]; opnd = x; cnt = mcnt[7:0]; cf_in = ci; of_in = oi;
        @(posedge clk);
        #1;
        gf = {cf_o, of_o, cf_we, of_we, sf_we, zf_we, pf_we,
              sf_o & sf_we, zf_o & zf_we, pf_o & pf_we, 2'b00};
        total++;
        if (res !== er || gf !== ef) begin
            bad++;
            $display("FAIL %s op=%0d sz=%0d x=%h cnt=%0d: got res=%h fl=%b exp res=%h fl=%b",
                     tag, mop, msz, x, mcnt, res, gf, er, ef);
        end
    endtask

    task automatic t_reset_state();
        check_vec("R4", 0, 0, 32'h0, 0, 1'b0, 1'b0);
        check_vec("R4", 2, 2, 32'h8000_0001, 0, 1'b1, 1'b1);
        check_vec("R4", 7, 1, 32'h1234_5678, 5, 1'b1, 1'b0);
    endtask

    task automatic t_count_mask();
        check_vec("R1", 0, 0, 32'h0000_0081, 33, 1'b0, 1'b0);
        check_vec("R1", 1, 2, 32'hF000_000F, 32, 1'b0, 1'b1);
        check_vec("R1", 3, 1, 32'h0000_8001, 255, 1'b0, 1'b0);
    endtask

    task automatic t_ring_count();
        check_vec("R2", 5, 0, 32'h0000_00A5, 9, 1'b1, 1'b0);
        check_vec("R2", 5, 0, 32'h0000_00A5, 10, 1'b1, 1'b0);
        check_vec("R2", 6, 1, 32'h0000_1234, 17, 1'b0, 1'b1);
        check_vec("R2", 6, 1, 32'h0000_1234, 18, 1'b1, 1'b1);
        check_vec("R2", 5, 2, 32'h8765_4321, 31, 1'b1, 1'b0);
    endtask

    task automatic t_ring_carry();
        check_vec("R3", 5, 0, 32'h0000_0080, 1, 1'b0, 1'b0);
        check_vec("R3", 6, 2, 32'h0000_0001, 1, 1'b1, 1'b0);
        check_vec("R3", 5, 1, 32'h0000_4000, 2, 1'b1, 1'b0);
        check_vec("R3", 6, 0, 32'h0000_0003, 8, 1'b0, 1'b1);
    endtask

    task automatic t_left_shift();
        check_vec("R5", 0, 0, 32'h0000_0001, 8, 1'b0, 1'b0);
        check_vec("R5", 0, 0, 32'h0000_00FF, 9, 1'b1, 1'b0);
        check_vec("R5", 0, 1, 32'h0000_C000, 1, 1'b0, 1'b1);
    endtask

    task automatic t_right_carry();
        check_vec("R6", 1, 1, 32'h0000_0004, 3, 1'b0, 1'b0);
        check_vec("R6", 2, 0, 32'h0000_0080, 20, 1'b0, 1'b0);
        check_vec("R6", 1, 0, 32'h0000_0080, 9, 1'b1, 1'b0);
    endtask

    task automatic t_sign_fill();
        check_vec("R7", 2, 2, 32'h8000_0000, 4, 1'b0, 1'b0);
        check_vec("R7", 2, 1, 32'h0000_8421, 16, 1'b0, 1'b0);
        check_vec("R7", 2, 0, 32'h0000_0070, 31, 1'b1, 1'b1);
    endtask

    task automatic t_result_flags();
        check_vec("R8", 0, 0, 32'h0000_0003, 2, 1'b0, 1'b0);
        check_vec("R8", 1, 1, 32'h0000_0100, 9, 1'b0, 1'b0);
        check_vec("R8", 0, 2, 32'h4000_0300, 1, 1'b0, 1'b0);
    endtask

    task automatic t_overflow();
        for (int o = 0; o < 7; o++) begin
            check_vec("R9", o, 0, 32'h0000_00C1, 1, 1'b1, 1'b0);
            check_vec("R9", o, 1, 32'h0000_4001, 1, 1'b0, 1'b1);
            check_vec("R9", o, 2, 32'h8000_0002, 2, 1'b0, 1'b1);
        end
    endtask

    task automatic t_plain_rotate();
        check_vec("R10", 3, 0, 32'h0000_0081, 8, 1'b0, 1'b0);
        check_vec("R10", 4, 1, 32'h0000_0013, 5, 1'b0, 1'b0);
        check_vec("R10", 4, 2, 32'h0000_0001, 31, 1'b0, 1'b0);
    endtask

    task automatic t_upper_pass();
        check_vec("R11", 1, 0, 32'hDEAD_BE81, 1, 1'b0, 1'b0);
        check_vec("R11", 0, 1, 32'hCAFE_8001, 3, 1'b0, 1'b0);
        check_vec("R11", 2, 3, 32'h8000_00F0, 4, 1'b0, 1'b0);
    endtask

    task automatic t_sweep();
        int cl[10] = '{0, 1, 2, 7, 8, 9, 16, 17, 31, 33};
        logic [31:0] pats[2] = '{32'h9A5C_3E81, 32'h0F00_8001};
        for (int o = 0; o < 8; o++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 10; c++)
                    for (int p = 0; p < 2; p++)
                        check_vec("R8", o, s, pats[p], cl[c], p[0], ~p[0]);
    endtask

    initial begin
        opnd = '0; cnt = '0; op = '0; size = '0; cf_in = 1'b0; of_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_count_mask();
        t_ring_count();
        t_ring_carry();
        t_left_shift();
        t_right_carry();
        t_sign_fill();
        t_result_flags();
        t_overflow();
        t_plain_rotate();
        t_upper_pass();
        t_sweep();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule